// File: doc/BRIEF.md
# Serial Converter Frame and Power-Mode Tracker

This block is the digital front end of a 10-bit serial sampling converter, written as synthesizable logic that runs on a fast system clock. It oversamples an active-low chip select and a serial clock, finds their edges, and counts the falling serial-clock edges in each frame. From the point at which chip select returns high, it decides whether the converter powers down, keeps running with the current word cut short, or finishes the frame normally.

A conversion result arrives on a parallel port and is captured when chip select falls. The block then shifts it out on a tri-statable data line as a 16-clock word. The word starts with three zero bits, carries the ten result bits most significant first, and ends with three zero bits. Every bit changes after a falling serial-clock edge. The block also reports the current power mode, pulses for a truncated frame and for a completed frame, and a flag that marks the first frame after wake-up as carrying an invalid result.

Top module: `ssr_mode_tracker`

## Requirements
- R1: A falling edge of `cs_n` puts the block in normal mode (`mode_normal`=1), clears the falling-edge count to 0 and captures `conv_word` for the new frame.
- R2: If `cs_n` rises after fewer than 10 falling `sclk` edges in the frame, the block enters shutdown mode (`mode_normal`=0) and `frame_abort` does not pulse.
- R3: In shutdown mode, toggling `sclk` with `cs_n` high leaves `mode_normal` at 0 and `sdata_oe` at 0, until `cs_n` falls again.
- R4: If `cs_n` rises after 10 to 15 falling `sclk` edges, `mode_normal` stays 1, `frame_abort` pulses high for exactly one clock and `sdata_oe` drops to 0.
- R5: On the 16th falling `sclk` edge of a frame, `frame_done` pulses high for exactly one clock and `sdata_oe` drops to 0. `cs_n` rising after that leaves the block in normal mode.
- R6: While enabled, after p falling `sclk` edges (p = 0..15), `sdata` is bit p of the 16-bit frame. Positions 0-2 are 0, position 3+k is `conv_word[9-k]` for k = 0..9, and positions 13-15 are 0. The result is straight binary.
- R7: After reset the block is in shutdown mode with `sdata_oe`, `sdata`, `frame_abort`, `frame_done` and `wake_frame` all 0. While `cs_n` is high, `sdata_oe` and `sdata` are 0.
- R8: A frame that starts from shutdown mode sets `wake_frame` to 1 for that whole frame. A frame that starts in normal mode clears it to 0.
- R9: The falling-edge count saturates at 16. Further `sclk` falls in the same frame produce no second `frame_done` and leave `sdata_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| conv_word | input | 10 | Conversion result to send, captured at frame start |
| sdata | output | 1 | Serial data; 0 when not enabled |
| sdata_oe | output | 1 | Output enable for the tri-state data pad |
| mode_normal | output | 1 | 1 = normal mode, 0 = shutdown |
| frame_abort | output | 1 | One-clock pulse when a frame is truncated |
| frame_done | output | 1 | One-clock pulse on the 16th falling `sclk` edge |
| wake_frame | output | 1 | Current frame began in shutdown; its result is invalid |

## Verification
The bench sends full frames with several result patterns: alternating bits, all ones, a lone low bit and a mixed value. These show whether the bit ordering and the placement of the zero padding are right, bit by bit.

Frames are also cut off at 5, 9, 10 and 12 falling edges. Cuts at 9 and 10 sit on either side of the threshold between shutdown and truncation. The cuts at 5 and 12 confirm each outcome away from that threshold.

A frame that runs past 16 edges shows that the count saturates. Frames that start from shutdown and from normal mode show the difference in the wake flag.

// File: rtl/ssr_pkg.sv
// Shared types for the serial converter mode tracker.
// Assumes: nothing beyond the standard language.
package ssr_pkg;
    typedef enum logic {
        MODE_SHUTDOWN = 1'b0,
        MODE_NORMAL   = 1'b1
    } ssr_mode_e;
endpackage

// File: rtl/ssr_edge_sync.sv
// Brings one asynchronous input into the clk domain and reports its edges.
// Assumes: the input stays stable for several clk periods between changes.
module ssr_edge_sync #(
    parameter int SYNC_STAGES = 2,
    parameter bit RESET_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES:0] pipe;

    // Shift the input through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {(SYNC_STAGES+1){RESET_VAL}};
        end else begin
            pipe <= {pipe[SYNC_STAGES-1:0], din};
        end
    end

    // Compare the synchronized level with its previous value.
    always_comb begin
        level = pipe[SYNC_STAGES-1];
        rise  = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
        fall  = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];
    end
endmodule

// File: rtl/ssr_edge_count.sv
// Counts falling serial-clock edges within one frame, saturating at the frame length.
// Assumes: clr and inc come from synchronized edge pulses.
module ssr_edge_count #(
    parameter int FRAME_LEN = 16,
    localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LEN);

    // Clear at frame start; step on each counted edge until saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt < CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ssr_frame_shifter.sv
// Captures the conversion word at frame start and presents the frame bit
// selected by the edge count, with lead and trail zero padding.
// Assumes: cnt is cleared on the same cycle as capture.
module ssr_frame_shifter #(
    parameter int DATA_W    = 10,
    parameter int LEAD_ZERO = 3,
    parameter int FRAME_LEN = 16,
    localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] word_in,
    input  logic              drive_en,
    input  logic [CNT_W-1:0]  cnt,
    output logic              sdata,
    output logic              sdata_oe
);
    logic [DATA_W-1:0] word_q;
    logic              bit_now;
    logic              oe_now;

    // Hold the result for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (capture) begin
            word_q <= word_in;
        end
    end

    // Select the frame bit for the current position.
    always_comb begin
        int pos;
        pos     = int'(cnt);
        bit_now = 1'b0;
        if (pos >= LEAD_ZERO && pos < LEAD_ZERO + DATA_W) begin
            bit_now = word_q[DATA_W - 1 - (pos - LEAD_ZERO)];
        end
        oe_now = drive_en && (pos < FRAME_LEN);
    end

    // Register the pad outputs; data is forced low when not driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata    <= 1'b0;
            sdata_oe <= 1'b0;
        end else begin
            sdata    <= oe_now & bit_now;
            sdata_oe <= oe_now;
        end
    end
endmodule

// File: rtl/ssr_mode_tracker.sv
// Top of the serial converter front end: tracks power mode from where chip
// select rises within a frame, flags truncated and completed frames, and
// marks the first frame after wake-up.
// Assumes: cs_n and sclk are slow relative to clk.
module ssr_mode_tracker #(
    parameter int DATA_W     = 10,
    parameter int FRAME_LEN  = 16,
    parameter int LEAD_ZERO  = 3,
    parameter int KEEP_EDGE  = 10,
    localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] conv_word,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              mode_normal,
    output logic              frame_abort,
    output logic              frame_done,
    output logic              wake_frame
);
    import ssr_pkg::*;

    localparam logic [CNT_W-1:0] KEEP_CNT = CNT_W'(KEEP_EDGE);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_LEN);

    logic             cs_lvl, cs_rise, cs_fall;
    logic             sclk_lvl, sclk_rise, sclk_fall;
    logic [CNT_W-1:0] cnt;
    logic             frame_active;
    logic             edge_inc;
    ssr_mode_e        mode_q;

    ssr_edge_sync #(.SYNC_STAGES(2), .RESET_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );

    ssr_edge_sync #(.SYNC_STAGES(2), .RESET_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
    );

    assign edge_inc = sclk_fall && frame_active && !cs_lvl;

    ssr_edge_count #(.FRAME_LEN(FRAME_LEN)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(cs_fall), .inc(edge_inc), .cnt(cnt)
    );

    ssr_frame_shifter #(
        .DATA_W(DATA_W), .LEAD_ZERO(LEAD_ZERO), .FRAME_LEN(FRAME_LEN)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .capture(cs_fall), .word_in(conv_word),
        .drive_en(frame_active && !cs_lvl), .cnt(cnt),
        .sdata(sdata), .sdata_oe(sdata_oe)
    );

    // Track frame membership, power mode and the wake-up marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_active <= 1'b0;
            mode_q       <= MODE_SHUTDOWN;
            wake_frame   <= 1'b0;
        end else if (cs_fall) begin
            frame_active <= 1'b1;
            mode_q       <= MODE_NORMAL;
            wake_frame   <= (mode_q == MODE_SHUTDOWN);
        end else if (cs_rise) begin
            frame_active <= 1'b0;
            if (frame_active && cnt < KEEP_CNT) begin
                mode_q <= MODE_SHUTDOWN;
            end
        end
    end

    // Generate one-clock pulses for truncated and completed frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_abort <= 1'b0;
            frame_done  <= 1'b0;
        end else begin
            frame_abort <= cs_rise && frame_active && cnt >= KEEP_CNT && cnt < FULL_CNT;
            frame_done  <= edge_inc && cnt == LAST_CNT;
        end
    end

    assign mode_normal = (mode_q == MODE_NORMAL);

    // Serial clock level and rise are observed only through the fall pulse.
    logic unused_ok;
    assign unused_ok = sclk_lvl ^ sclk_rise;
endmodule

// File: rtl/ssr_mode_tracker_chk.sv
// Property checker for ssr_mode_tracker, attached by bind.
// Assumes: signal names of the top module as listed in the bind below.
module ssr_mode_tracker_chk #(
    parameter int FRAME_LEN = 16,
    parameter int KEEP_EDGE = 10,
    localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_lvl,
    input logic             cs_rise,
    input logic             cs_fall,
    input logic             frame_active,
    input logic [CNT_W-1:0] cnt,
    input logic             sdata_oe,
    input logic             mode_normal,
    input logic             frame_abort,
    input logic             frame_done
);
    // R1: frame start enters normal mode with a cleared count
    p_start_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (mode_normal && cnt == '0));

    // R2: early chip-select release powers down
    p_early_release_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && frame_active && int'(cnt) < KEEP_EDGE) |=> !mode_normal);

    // R4: a truncated frame keeps normal mode
    p_abort_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |-> mode_normal);

    // R5: completion is a single-clock pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R5: output released once the frame is full
    p_full_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) == FRAME_LEN) |=> !sdata_oe);

    // R7: no drive while chip select is high
    p_cs_high_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> !sdata_oe);

    // R9: count never exceeds the frame length
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= FRAME_LEN);
endmodule

bind ssr_mode_tracker ssr_mode_tracker_chk #(
    .FRAME_LEN(FRAME_LEN), .KEEP_EDGE(KEEP_EDGE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .frame_active(frame_active), .cnt(cnt),
    .sdata_oe(sdata_oe), .mode_normal(mode_normal),
    .frame_abort(frame_abort), .frame_done(frame_done)
);

// File: tb/sim_ssr_mode_tracker.sv
// Directed bench for ssr_mode_tracker: one task per scenario.
module sim_ssr_mode_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic [9:0] conv_word = '0;
    logic       sdata, sdata_oe, mode_normal, frame_abort, frame_done, wake_frame;

    int checks = 0;
    int errors = 0;
    int n_done = 0;
    int n_abort = 0;

    always #2.5 clk = ~clk;

    ssr_mode_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_word(conv_word),
        .sdata(sdata), .sdata_oe(sdata_oe), .mode_normal(mode_normal),
        .frame_abort(frame_abort), .frame_done(frame_done), .wake_frame(wake_frame)
    );

    // Count output pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_done)  n_done++;
            if (frame_abort) n_abort++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait long enough for synchronizer and output registers, then land on a falling clk edge.
    task automatic settle();
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk = 1'b0; settle();
        sclk = 1'b1; settle();
    endtask

    function automatic logic frame_bit(input logic [9:0] w, input int p);
        logic [15:0] v;
        v = {3'b000, w, 3'b000};
        return v[15 - p];
    endfunction

    task automatic t_reset();
        chk("R7", "reset mode", mode_normal, 0);
        chk("R7", "reset oe", sdata_oe, 0);
        chk("R7", "reset sdata", sdata, 0);
        chk("R7", "reset abort", frame_abort, 0);
        chk("R7", "reset done", frame_done, 0);
        chk("R7", "reset wake", wake_frame, 0);
    endtask

    // Full 16-edge frame with bit-by-bit checks, then saturation.
    task automatic t_full_frame(input logic [9:0] w, input logic exp_wake);
        int d0;
        conv_word = w;
        cs_n = 1'b0; settle();
        conv_word = ~w;
        chk("R1", "mode after cs low", mode_normal, 1);
        chk("R8", "wake flag", wake_frame, exp_wake);
        chk("R6", "oe at pos0", sdata_oe, 1);
        chk("R6", "bit pos0", sdata, frame_bit(w, 0));
        d0 = n_done;
        for (int p = 1; p <= 16; p++) begin
            sclk = 1'b0; settle();
            if (p < 16) begin
                chk("R6", $sformatf("bit pos%0d", p), sdata, frame_bit(w, p));
                chk("R6", "oe mid frame", sdata_oe, 1);
            end
            sclk = 1'b1; settle();
        end
        chk("R5", "done pulses", n_done - d0, 1);
        chk("R5", "oe after 16", sdata_oe, 0);
        for (int k = 0; k < 3; k++) sclk_pulse();
        chk("R9", "done after extra edges", n_done - d0, 1);
        chk("R9", "oe after extra edges", sdata_oe, 0);
        cs_n = 1'b1; settle();
        chk("R5", "mode after full frame", mode_normal, 1);
        chk("R7", "oe cs high", sdata_oe, 0);
        chk("R7", "sdata cs high", sdata, 0);
    endtask

    // Frame cut off after n falling edges.
    task automatic t_cut(input int n, input logic exp_normal, input int exp_abort);
        int a0;
        conv_word = 10'h3FF;
        cs_n = 1'b0; settle();
        a0 = n_abort;
        for (int k = 0; k < n; k++) sclk_pulse();
        cs_n = 1'b1; settle();
        if (exp_normal) begin
            chk("R4", $sformatf("mode cut at %0d", n), mode_normal, 1);
            chk("R4", $sformatf("abort cut at %0d", n), n_abort - a0, exp_abort);
            chk("R4", "oe after abort", sdata_oe, 0);
        end else begin
            chk("R2", $sformatf("mode cut at %0d", n), mode_normal, 0);
            chk("R2", $sformatf("abort cut at %0d", n), n_abort - a0, exp_abort);
        end
    endtask

    // sclk activity with cs high while in shutdown.
    task automatic t_idle_shutdown();
        for (int k = 0; k < 20; k++) sclk_pulse();
        chk("R3", "mode stays shutdown", mode_normal, 0);
        chk("R3", "oe stays low", sdata_oe, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_full_frame(10'h2AA, 1'b1);
        t_full_frame(10'h3FF, 1'b0);
        t_full_frame(10'h37F, 1'b0);
        t_cut(5, 1'b0, 0);
        t_idle_shutdown();
        t_full_frame(10'h155, 1'b1);
        t_cut(12, 1'b1, 1);
        t_cut(10, 1'b1, 1);
        t_cut(9, 1'b0, 0);
        t_full_frame(10'h0C3, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule